// File: doc/BRIEF.md
# Bus-Matching Width Converter

This block sits between a 36-bit FIFO word path and a narrower external port whose size is chosen when the block comes out of reset. The port is either 18 bits wide (word size) or 9 bits wide (byte size). On the packing side, narrow writes are gathered into one 36-bit long word. That long word is offered to the FIFO through a valid/ready handshake only after the write that fills its last slice. On the unpacking side, a 36-bit long word is taken from the FIFO through a valid/ready handshake and handed out one slice per read.

A lane-order input is captured together with the size select while the master reset is asserted. It decides whether the first narrow transfer of a long word maps to its most significant slice (big-endian) or its least significant slice (little-endian). A synchronous partial clear empties both directions and restarts the slice counting. It keeps the captured configuration.

Top module: `bus_match_conv`

## Requirements
- R1: With size_byte_i captured HIGH, four accepted 9-bit writes form one long word. With it captured LOW, two accepted 18-bit writes form one long word.
- R2: Packing lane order follows the captured big_end_i. When it is HIGH, write k of a long word (k from 0) fills slice N-1-k, where slice 0 is bits [w-1:0] and N = 36/w. When it is LOW, write k fills slice k.
- R3: pk_valid_o rises only in the cycle after the write that completes a long word has been accepted (wr_valid_i and wr_ready_o both high).
- R4: While pk_valid_o is high and pk_ready_i is low, pk_valid_o and pk_data_o hold their values and wr_ready_o is low. Otherwise wr_ready_o is high.
- R5: In byte size only wr_data_i[8:0] is stored, and bits [17:9] have no effect on pk_data_o. In word size all 18 bits are stored.
- R6: Each long word is read out as N slices, in the same lane order as R2.
- R7: During byte-size reads, rd_data_o[17:9] is driven to zero.
- R8: A new long word is taken (up_ready_o high) only when no word is held, or when rd_en_i consumes the last slice of the held word. While a word is held and rd_en_i is low, rd_valid_o and rd_data_o hold their values.
- R9: size_byte_i and big_end_i are sampled only while rst_ni is low. Changes to them after reset do not alter packing or unpacking.
- R10: clr_i drops both pending long words, restarts slice counting at the first slice, and keeps the captured configuration.
- R11: During and right after reset, pk_valid_o and rd_valid_o are low, and wr_ready_o and up_ready_o are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous master reset; captures configuration |
| clr_i | input | 1 | Synchronous partial clear |
| size_byte_i | input | 1 | 1 = byte size, 0 = word size (sampled in reset) |
| big_end_i | input | 1 | 1 = first transfer is most significant slice (sampled in reset) |
| wr_valid_i | input | 1 | Narrow write request |
| wr_data_i | input | 18 | Narrow write data |
| wr_ready_o | output | 1 | Narrow write can be accepted |
| pk_valid_o | output | 1 | Packed long word available |
| pk_data_o | output | 36 | Packed long word |
| pk_ready_i | input | 1 | FIFO accepts the packed word |
| up_valid_i | input | 1 | Long word available from FIFO |
| up_data_i | input | 36 | Long word from FIFO |
| up_ready_o | output | 1 | Long word taken this cycle when up_valid_i |
| rd_en_i | input | 1 | Narrow read enable |
| rd_valid_o | output | 1 | A slice is available on rd_data_o |
| rd_data_o | output | 18 | Narrow read data |

## Verification
All four combinations of size and lane order are run. In each, a directed long word is built from distinct slices whose unused upper bits are set to ones, which shows up any swapped slice order or leaked unused bits. Random traffic with back-pressure on both handshakes, occasional partial clears and configuration pins toggled in the middle of a run is compared every cycle against a queue-and-integer model. That comparison separates slice-counting errors, stall-hold errors and premature pops from one another, and shows whether the configuration stays locked after reset.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  typedef struct packed {
    logic byte_mode;
    logic big_end;
  } bmc_cfg_t;

  // physical slice for the k-th transfer of a long word
  function automatic int lane_pos(input int idx, input int n, input logic big);
    return big ? (n - 1 - idx) : idx;
  endfunction
endpackage

// File: rtl/bmc_pack.sv
module bmc_pack
  import bmc_pkg::*;
#(
  parameter int LONG_W   = 36,
  parameter int NARROW_W = 18,
  parameter int BYTE_W   = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  bmc_cfg_t            cfg_i,
  input  logic                wr_valid_i,
  input  logic [NARROW_W-1:0] wr_data_i,
  output logic                wr_ready_o,
  output logic                pk_valid_o,
  output logic [LONG_W-1:0]   pk_data_o,
  input  logic                pk_ready_i
);
  localparam int LANES  = LONG_W / BYTE_W;
  localparam int WORD_N = LONG_W / NARROW_W;
  localparam int LPW    = NARROW_W / BYTE_W;
  localparam int CNT_W  = (LANES > 1) ? $clog2(LANES) : 1;

  logic [CNT_W-1:0]  cnt_q, pos, nm1;
  logic [LONG_W-1:0] acc_q, acc_d, pkd_q;
  logic              pkv_q, last, wr_fire;

  assign nm1        = cfg_i.byte_mode ? CNT_W'(LANES - 1) : CNT_W'(WORD_N - 1);
  assign last       = (cnt_q == nm1);
  assign pos        = CNT_W'(lane_pos(int'(cnt_q), int'(nm1) + 1, cfg_i.big_end));
  assign wr_ready_o = !pkv_q || pk_ready_i;
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign pk_valid_o = pkv_q;
  assign pk_data_o  = pkd_q;

  always_comb begin
    acc_d = acc_q;
    for (int l = 0; l < LANES; l++) begin
      if (cfg_i.byte_mode) begin
        if (CNT_W'(l) == pos) acc_d[l*BYTE_W +: BYTE_W] = wr_data_i[BYTE_W-1:0];
      end else if (CNT_W'(l / LPW) == pos) begin
        acc_d[l*BYTE_W +: BYTE_W] = wr_data_i[(l % LPW)*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
      pkv_q <= 1'b0;
      pkd_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      pkv_q <= 1'b0;
    end else begin
      if (pkv_q && pk_ready_i) pkv_q <= 1'b0;
      if (wr_fire) begin
        acc_q <= acc_d;
        if (last) begin
          cnt_q <= '0;
          pkv_q <= 1'b1;
          pkd_q <= acc_d;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bmc_unpack.sv
module bmc_unpack
  import bmc_pkg::*;
#(
  parameter int LONG_W   = 36,
  parameter int NARROW_W = 18,
  parameter int BYTE_W   = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  bmc_cfg_t            cfg_i,
  input  logic                up_valid_i,
  input  logic [LONG_W-1:0]   up_data_i,
  output logic                up_ready_o,
  input  logic                rd_en_i,
  output logic                rd_valid_o,
  output logic [NARROW_W-1:0] rd_data_o
);
  localparam int LANES  = LONG_W / BYTE_W;
  localparam int WORD_N = LONG_W / NARROW_W;
  localparam int CNT_W  = (LANES > 1) ? $clog2(LANES) : 1;

  logic [CNT_W-1:0]  idx_q, pos, nm1;
  logic [LONG_W-1:0] cur_q;
  logic              cv_q, last;

  assign nm1        = cfg_i.byte_mode ? CNT_W'(LANES - 1) : CNT_W'(WORD_N - 1);
  assign last       = (idx_q == nm1);
  assign pos        = CNT_W'(lane_pos(int'(idx_q), int'(nm1) + 1, cfg_i.big_end));
  assign up_ready_o = !cv_q || (rd_en_i && last);
  assign rd_valid_o = cv_q;

  always_comb begin
    rd_data_o = '0;
    if (cfg_i.byte_mode) rd_data_o[BYTE_W-1:0] = cur_q[int'(pos)*BYTE_W +: BYTE_W];
    else                 rd_data_o = cur_q[int'(pos)*NARROW_W +: NARROW_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      cv_q  <= 1'b0;
      idx_q <= '0;
    end else if (clr_i) begin
      cv_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      if (cv_q && rd_en_i) begin
        if (last) begin
          cv_q  <= 1'b0;
          idx_q <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
      if (up_valid_i && up_ready_o) begin
        cur_q <= up_data_i;
        cv_q  <= 1'b1;
        idx_q <= '0;
      end
    end
  end
endmodule

// File: rtl/bus_match_conv.sv
module bus_match_conv
  import bmc_pkg::*;
#(
  parameter int LONG_W   = 36,
  parameter int NARROW_W = 18,
  parameter int BYTE_W   = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                size_byte_i,
  input  logic                big_end_i,
  input  logic                wr_valid_i,
  input  logic [NARROW_W-1:0] wr_data_i,
  output logic                wr_ready_o,
  output logic                pk_valid_o,
  output logic [LONG_W-1:0]   pk_data_o,
  input  logic                pk_ready_i,
  input  logic                up_valid_i,
  input  logic [LONG_W-1:0]   up_data_i,
  output logic                up_ready_o,
  input  logic                rd_en_i,
  output logic                rd_valid_o,
  output logic [NARROW_W-1:0] rd_data_o
);
  logic     cfg_byte_q, cfg_big_q;
  bmc_cfg_t cfg;

  // configuration follows the pins only while master reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_byte_q <= size_byte_i;
      cfg_big_q  <= big_end_i;
    end
  end

  assign cfg = '{byte_mode: cfg_byte_q, big_end: cfg_big_q};

  bmc_pack #(.LONG_W(LONG_W), .NARROW_W(NARROW_W), .BYTE_W(BYTE_W)) u_pack (
    .clk_i, .rst_ni, .clr_i, .cfg_i(cfg),
    .wr_valid_i, .wr_data_i, .wr_ready_o,
    .pk_valid_o, .pk_data_o, .pk_ready_i
  );

  bmc_unpack #(.LONG_W(LONG_W), .NARROW_W(NARROW_W), .BYTE_W(BYTE_W)) u_unpack (
    .clk_i, .rst_ni, .clr_i, .cfg_i(cfg),
    .up_valid_i, .up_data_i, .up_ready_o,
    .rd_en_i, .rd_valid_o, .rd_data_o
  );
endmodule

// File: rtl/bmc_checker.sv
module bmc_checker #(
  parameter int LONG_W   = 36,
  parameter int NARROW_W = 18,
  parameter int BYTE_W   = 9
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                clr_i,
  input logic                cfg_byte,
  input logic                cfg_big,
  input logic                wr_valid_i,
  input logic                wr_ready_o,
  input logic                pk_valid_o,
  input logic [LONG_W-1:0]   pk_data_o,
  input logic                pk_ready_i,
  input logic                up_ready_o,
  input logic                rd_en_i,
  input logic                rd_valid_o,
  input logic [NARROW_W-1:0] rd_data_o
);
  AST_PK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pk_valid_o && !pk_ready_i && !clr_i) |=> (pk_valid_o && $stable(pk_data_o))); // R4
  AST_WR_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pk_valid_o && !pk_ready_i) |-> !wr_ready_o); // R4
  AST_PK_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pk_valid_o) |-> $past(wr_valid_i && wr_ready_o && !clr_i)); // R3
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_en_i && !clr_i) |=> (rd_valid_o && $stable(rd_data_o))); // R8
  AST_UP_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_en_i) |-> !up_ready_o); // R8
  AST_BYTE_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && cfg_byte) |-> (rd_data_o[NARROW_W-1:BYTE_W] == '0)); // R7
  AST_CFG_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(rst_ni) |-> ($stable(cfg_byte) && $stable(cfg_big))); // R9
endmodule

bind bus_match_conv bmc_checker #(.LONG_W(LONG_W), .NARROW_W(NARROW_W), .BYTE_W(BYTE_W)) u_bmc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
  .cfg_byte(cfg_byte_q), .cfg_big(cfg_big_q),
  .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
  .pk_valid_o(pk_valid_o), .pk_data_o(pk_data_o), .pk_ready_i(pk_ready_i),
  .up_ready_o(up_ready_o), .rd_en_i(rd_en_i),
  .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
);

// File: tb/bus_match_conv_bench.sv
module bus_match_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0, size_pin = 1'b0, big_pin = 1'b0;
  logic        wr_valid = 1'b0, pk_ready = 1'b0, up_valid = 1'b0, rd_en = 1'b0;
  logic [17:0] wr_data = '0;
  logic [35:0] up_data = '0;
  logic        wr_ready, pk_valid, up_ready, rd_valid;
  logic [35:0] pk_data;
  logic [17:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_match_conv u_bus_match_conv (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
    .size_byte_i(size_pin), .big_end_i(big_pin),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .pk_valid_o(pk_valid), .pk_data_o(pk_data), .pk_ready_i(pk_ready),
    .up_valid_i(up_valid), .up_data_i(up_data), .up_ready_o(up_ready),
    .rd_en_i(rd_en), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit          m_byte, m_big, m_pkv, m_cv;
  int          m_cnt, m_idx;
  logic [35:0] m_acc, m_pkd, m_cur;

  function automatic int slices(); return m_byte ? 4 : 2; endfunction
  function automatic int swid();   return m_byte ? 9 : 18; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_byte = size_pin; m_big = big_pin;
      m_cnt = 0; m_idx = 0; m_pkv = 0; m_cv = 0;
    end else if (clr) begin
      m_cnt = 0; m_idx = 0; m_pkv = 0; m_cv = 0;
    end else begin
      int n, w, p;
      bit wacc, uacc, rdo;
      n = slices(); w = swid();
      wacc = wr_valid && (!m_pkv || pk_ready);
      uacc = up_valid && (!m_cv || (rd_en && m_idx == n - 1));
      rdo  = m_cv && rd_en;
      if (m_pkv && pk_ready) m_pkv = 0;
      if (wacc) begin
        p = m_big ? n - 1 - m_cnt : m_cnt;
        for (int b = 0; b < w; b++) m_acc[p*w + b] = wr_data[b];
        if (m_cnt == n - 1) begin m_pkd = m_acc; m_pkv = 1; m_cnt = 0; end
        else m_cnt++;
      end
      if (rdo) begin
        if (m_idx == n - 1) begin m_cv = 0; m_idx = 0; end
        else m_idx++;
      end
      if (uacc) begin m_cur = up_data; m_cv = 1; m_idx = 0; end
    end
  end

  function automatic logic [17:0] exp_rd();
    logic [17:0] r;
    int n, w, p;
    n = slices(); w = swid();
    p = m_big ? n - 1 - m_idx : m_idx;
    r = '0;
    for (int b = 0; b < w; b++) r[b] = m_cur[p*w + b];
    return r;
  endfunction

  // compared every cycle at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int n;
      n = slices();
      chk("R4 wr_ready", 64'(wr_ready), 64'(!m_pkv || pk_ready));
      chk("R3 pk_valid", 64'(pk_valid), 64'(m_pkv));
      if (m_pkv) chk("R1 R2 R5 pk_data", 64'(pk_data), 64'(m_pkd));
      chk("R8 rd_valid", 64'(rd_valid), 64'(m_cv));
      chk("R8 up_ready", 64'(up_ready), 64'(!m_cv || (rd_en && m_idx == n - 1)));
      if (m_cv) chk("R6 R7 rd_data", 64'(rd_data), 64'(exp_rd()));
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic idle();
    wr_valid = 0; pk_ready = 0; up_valid = 0; rd_en = 0; clr = 0;
  endtask

  task automatic do_reset(input bit sz, input bit be);
    @(posedge clk); #2;
    idle(); size_pin = sz; big_pin = be; rst_n = 0;
    repeat (3) step();
    #3;
    chk("R11 pk_valid in reset", 64'(pk_valid), 64'd0);
    chk("R11 rd_valid in reset", 64'(rd_valid), 64'd0);
    chk("R11 wr_ready in reset", 64'(wr_ready), 64'd1);
    chk("R11 up_ready in reset", 64'(up_ready), 64'd1);
    @(posedge clk); #2;
    rst_n = 1;
  endtask

  task automatic directed(input bit sz, input bit be);
    logic [8:0]  b [4];
    logic [17:0] w [2];
    logic [35:0] exp;
    int n;
    b[0] = 9'h111; b[1] = 9'h022; b[2] = 9'h133; b[3] = 9'h044;
    w[0] = 18'h2AB12; w[1] = 18'h1C3D4;
    n = sz ? 4 : 2;
    if (sz) exp = be ? {b[0], b[1], b[2], b[3]} : {b[3], b[2], b[1], b[0]};
    else    exp = be ? {w[0], w[1]} : {w[1], w[0]};
    for (int k = 0; k < n; k++) begin
      wr_valid = 1;
      wr_data  = sz ? {9'h1FF, b[k]} : w[k]; // R5 junk in upper bits
      step();
      if (k < n - 1) begin
        #3; chk("R3 no commit before last slice", 64'(pk_valid), 64'd0); #2;
      end
    end
    wr_valid = 0;
    step(); #3;
    chk("R1 R2 R5 directed packed word", 64'(pk_data), 64'(exp));
    chk("R3 commit after last slice", 64'(pk_valid), 64'd1);
    #2; pk_ready = 1; step(); pk_ready = 0;
    // unpack the same word: first read follows R6 order, byte upper lanes R7
    up_valid = 1; up_data = exp; step(); up_valid = 0; #3;
    chk("R6 R7 first slice", 64'(rd_data), sz ? 64'(b[0]) : 64'(w[0]));
    #2; rd_en = 1; step(); rd_en = 0; #3;
    chk("R6 second slice", 64'(rd_data), sz ? 64'(b[1]) : 64'(w[1]));
    #2;
    // R10 partial clear drops held word, config kept
    clr = 1; step(); clr = 0; #3;
    chk("R10 clear drops read word", 64'(rd_valid), 64'd0);
    #2;
  endtask

  task automatic random_run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      if (i == cycles / 2) begin size_pin = ~size_pin; big_pin = ~big_pin; end // R9
      wr_valid = ($urandom % 3) != 0;
      wr_data  = 18'($urandom);
      pk_ready = ($urandom % 3) != 0;
      up_valid = ($urandom % 2) != 0;
      up_data  = {4'($urandom), 32'($urandom)};
      rd_en    = ($urandom % 3) != 0;
      clr      = ($urandom % 64) == 0; // R10
      step();
    end
    idle();
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin
      bit sz, be;
      sz = c[0]; be = c[1];
      do_reset(sz, be);
      directed(sz, be);
      random_run(500);
      step();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule